// File: doc/BRIEF.md
# Multi-Mode 4:2:2 Video Input Formatter

This block sits at the pixel input of a video output path. It takes enhanced- or high-definition luma/chroma 4:2:2 data in one of three bus formats. The first is a 16-bit bus carrying one luma and one chroma byte per clock. The second is a double-data-rate bus that puts luma and chroma on the same upper pins on opposite clock edges. The third is a single-edge interleaved bus running at twice the pixel rate. In every format the block hands downstream logic one aligned pixel pair per strobe: a luma word, a chroma word, and a flag that says whether the chroma is Cr or Cb.

The block scans the incoming word stream for embedded timing references. These are a full-scale word, two zero words and a flag word. The block removes them from the pixel stream and decodes the flag word into field, vertical-blank and start/end-of-active-video indications, with a protection check on the parity bits. A start-of-active-video code resets the chroma phase so that the next pair carries Cb. Configuration changes wait until such a code has been received, so a format switch never splits a pair.

The double-data-rate capture is modelled as two ports registered on one clock: `bus_rise` holds the word taken on the rising edge and `bus_fall` holds the word taken on the falling edge of the same period. All words are presented downstream as 10-bit values. An 8-bit word occupies the upper eight bits, and its two low bits are zero.

Top module: `vid422_formatter`

## Requirements
- R1: The active format settings (mode, luma edge, width) are loaded from the cfg inputs during reset and again only when an error-free start-of-active-video code (H=0) is decoded. Changing cfg at any other time has no effect on output. Mode encoding: 00 = 16-bit single rate, 01 = double rate, 10 = interleaved, 11 = behaves as 00.
- R2: In single-rate mode each captured `bus_rise` yields one pair, with luma from bits [15:8] and chroma from bits [7:0]. Both are output as {byte, 2'b00}. Timing codes are searched for on the luma byte only, with FF as the first code word.
- R3: In double-rate mode the rising-edge word comes first in stream order and the falling-edge word second. When cfg_luma_edge is 11, luma is the falling-edge word and chroma the rising-edge word. Any other value puts luma on the rising-edge word. A pair is emitted only for a clock in which neither word belongs to a timing code.
- R4: In double-rate and interleaved modes, with the width setting at 1 a word is bus bits [15:6] and the first code word is 3FF. With the width setting at 0 a word is {bits[15:8], 2'b00} and the first code word is 3FC.
- R5: In interleaved mode one word per clock is taken from `bus_rise`, in the order chroma, luma, chroma, luma. `bus_fall` is ignored. A pair is emitted for each luma word, together with the chroma word captured just before it.
- R6: A timing code is a first code word followed by 000, 000 and a flag word. All four words are withheld from the pixel stream. `trs_stb` pulses for exactly one cycle when the flag word is processed, and only if both middle words are zero. With a non-zero middle word the four words are still dropped, but `trs_stb` does not pulse.
- R7: The flag word is decoded from its upper eight bits: F at bit 6, V at bit 5, H at bit 4. `trs_err` is set when bit 7 is 0, when bits [3:0] differ from {V^H, F^H, F^V, F^V^H}, or when the two lowest bits of the 10-bit word are non-zero.
- R8: `pix_c_is_cr` is 0 on the first pair after reset and on the first pair after an error-free start-of-active-video code, and alternates on every pair in between.
- R9: `sync_h` and `sync_v` follow `hsync_in` and `vsync_in` with the same latency as pixel data in single- and double-rate modes. They are held at 0 while the active mode is interleaved.
- R10: Data presented before rising edge k is captured at edge k, and its outputs appear after edge k+1. While reset is held, `pix_valid`, `trs_stb`, `sync_h` and `sync_v` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and output clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the cfg inputs |
| cfg_mode | input | 2 | Requested bus format |
| cfg_luma_edge | input | 2 | Double-rate luma edge select (11 = falling) |
| cfg_wide | input | 1 | 10-bit shared-bus width select |
| bus_rise | input | 16 | Bus word captured on the rising edge |
| bus_fall | input | 16 | Bus word captured on the falling edge |
| hsync_in | input | 1 | External horizontal sync |
| vsync_in | input | 1 | External vertical sync |
| pix_valid | output | 1 | Pixel pair strobe |
| pix_y | output | 10 | Luma word of the pair |
| pix_c | output | 10 | Chroma word of the pair |
| pix_c_is_cr | output | 1 | 1 when pix_c is Cr, 0 when Cb |
| trs_stb | output | 1 | One-cycle pulse on a decoded timing code |
| trs_f | output | 1 | Field bit of the last code |
| trs_v | output | 1 | Vertical-blank bit of the last code |
| trs_h | output | 1 | 1 = end of active video, 0 = start |
| trs_err | output | 1 | Protection error on the last code |
| sync_h | output | 1 | Aligned horizontal sync, 0 in interleaved mode |
| sync_v | output | 1 | Aligned vertical sync, 0 in interleaved mode |

## Verification
The bench builds the block with its default parameters: 8-bit narrow words, 10-bit wide words, a 16-bit bus and two stream slots per clock. Because width is a run-time setting, this single build reaches both the 3FF and 3FC code preambles. In wide mode it also covers a 3FC data word, which must pass through as a pixel. The two slots let a code word fall in either the rising or the falling position of a double-rate clock. The bench moves through every mode change by means of start codes sent in the old format. It includes a start code with bad parity that must not switch the mode, and a broken preamble.

// File: rtl/vif_pkg.sv
// Shared types and helpers for the 4:2:2 video input formatter.
// Assumes an 8-bit narrow word, so the flag-word bit positions are fixed.
package vif_pkg;

    // Bus format; the reserved code behaves as the single-rate format.
    typedef enum logic [1:0] {
        MODE_SDR16 = 2'b00,
        MODE_DDR   = 2'b01,
        MODE_ILV   = 2'b10,
        MODE_RSVD  = 2'b11
    } vif_mode_e;

    // Active configuration, adopted at reset and at a clean start code.
    typedef struct packed {
        vif_mode_e mode;
        logic      luma_fall;
        logic      wide;
    } vif_cfg_t;

    // Protection bits expected for a given F/V/H triple.
    function automatic logic [3:0] trs_parity(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Fold the reserved mode onto single-rate behaviour.
    function automatic vif_mode_e eff_mode(input logic [1:0] raw);
        return (raw == MODE_RSVD) ? MODE_SDR16 : vif_mode_e'(raw);
    endfunction

endpackage

// File: rtl/vif_capture.sv
// Input capture stage: registers both half-clock bus ports and the sync pins.
// Assumes the double-rate pins have already been split into a rising-edge
// and a falling-edge word by the pad logic.
module vif_capture #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_rise,
    input  logic [BUS_W-1:0] bus_fall,
    input  logic             hsync_in,
    input  logic             vsync_in,
    output logic [BUS_W-1:0] cap_rise,
    output logic [BUS_W-1:0] cap_fall,
    output logic             cap_hs,
    output logic             cap_vs,
    output logic             cap_vld
);

    // Register every input; cap_vld marks that the registers hold real data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_rise <= '0;
            cap_fall <= '0;
            cap_hs   <= 1'b0;
            cap_vs   <= 1'b0;
            cap_vld  <= 1'b0;
        end else begin
            cap_rise <= bus_rise;
            cap_fall <= bus_fall;
            cap_hs   <= hsync_in;
            cap_vs   <= vsync_in;
            cap_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/vif_trs_scan.sv
// Timing-reference scanner. Walks up to SLOTS stream words per clock in slot
// order, withholds every word of a preamble+flag sequence and reports the
// flag word when both middle words were zero.
// Assumes a first-code word can never be pixel data.
module vif_trs_scan #(
    parameter int WORD_W = 10,
    parameter int SLOTS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS-1:0][WORD_W-1:0]  word_i,
    input  logic [SLOTS-1:0]              slot_en,
    input  logic [WORD_W-1:0]             first_code,
    output logic [SLOTS-1:0]              keep_o,
    output logic                          xy_hit,
    output logic [WORD_W-1:0]             xy_word
);

    localparam int POS_W = 2;

    logic [POS_W-1:0] pos_q, pos_d;
    logic             zok_q, zok_d;

    // Step the sequence position through each enabled slot in stream order.
    always_comb begin
        pos_d   = pos_q;
        zok_d   = zok_q;
        keep_o  = '0;
        xy_hit  = 1'b0;
        xy_word = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_en[s]) begin
                case (pos_d)
                    2'd0: begin
                        if (word_i[s] == first_code) pos_d = 2'd1;
                        else                         keep_o[s] = 1'b1;
                    end
                    2'd1: begin
                        zok_d = (word_i[s] == '0);
                        pos_d = 2'd2;
                    end
                    2'd2: begin
                        zok_d = zok_d && (word_i[s] == '0);
                        pos_d = 2'd3;
                    end
                    default: begin
                        if (zok_d) begin
                            xy_hit  = 1'b1;
                            xy_word = word_i[s];
                        end
                        pos_d = 2'd0;
                    end
                endcase
            end
        end
    end

    // Hold the sequence position across clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            zok_q <= 1'b0;
        end else begin
            pos_q <= pos_d;
            zok_q <= zok_d;
        end
    end

endmodule

// File: rtl/vif_pair_asm.sv
// Pixel-pair assembler. Forms {Y, C, c_is_cr} from the kept stream words
// according to the active format and tracks the Cb/Cr phase.
// Assumes no pixel word is kept in the cycle that carries a start code.
module vif_pair_asm
    import vif_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vif_mode_e         mode,
    input  logic              luma_fall,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] c_lane,
    input  logic              keep0,
    input  logic              keep1,
    input  logic              sav_clr,
    output logic              pix_valid,
    output logic [WORD_W-1:0] pix_y,
    output logic [WORD_W-1:0] pix_c,
    output logic              pix_c_is_cr
);

    logic              phase_q;
    logic              have_c_q;
    logic [WORD_W-1:0] c_hold_q;

    logic              emit;
    logic [WORD_W-1:0] emit_y, emit_c;

    // Decide whether this clock produces a pair and which words form it.
    always_comb begin
        emit   = 1'b0;
        emit_y = w0;
        emit_c = c_lane;
        case (mode)
            MODE_DDR: begin
                emit   = keep0 && keep1;
                emit_y = luma_fall ? w1 : w0;
                emit_c = luma_fall ? w0 : w1;
            end
            MODE_ILV: begin
                emit   = keep0 && have_c_q;
                emit_y = w0;
                emit_c = c_hold_q;
            end
            default: begin
                emit   = keep0;
                emit_y = w0;
                emit_c = c_lane;
            end
        endcase
    end

    // Register the pair, the chroma phase and the interleaved chroma hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid   <= 1'b0;
            pix_y       <= '0;
            pix_c       <= '0;
            pix_c_is_cr <= 1'b0;
            phase_q     <= 1'b0;
            have_c_q    <= 1'b0;
            c_hold_q    <= '0;
        end else begin
            pix_valid <= emit;
            if (emit) begin
                pix_y       <= emit_y;
                pix_c       <= emit_c;
                pix_c_is_cr <= phase_q;
                phase_q     <= ~phase_q;
            end
            if (mode == MODE_ILV && keep0) begin
                if (have_c_q) begin
                    have_c_q <= 1'b0;
                end else begin
                    have_c_q <= 1'b1;
                    c_hold_q <= w0;
                end
            end
            if (sav_clr) begin
                phase_q  <= 1'b0;
                have_c_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vid422_formatter.sv
// Multi-mode 4:2:2 input formatter top. Captures the bus, normalises words to
// WIDE_W bits, scans for timing codes, assembles pixel pairs and aligns the
// external sync pins. Format settings change only at reset or a clean start code.
// Assumes NARROW_W = 8 for the flag-word layout and WIDE_W > NARROW_W.
module vid422_formatter
    import vif_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 10,
    parameter int BUS_W    = 2 * NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_luma_edge,
    input  logic              cfg_wide,
    input  logic [BUS_W-1:0]  bus_rise,
    input  logic [BUS_W-1:0]  bus_fall,
    input  logic              hsync_in,
    input  logic              vsync_in,
    output logic              pix_valid,
    output logic [WIDE_W-1:0] pix_y,
    output logic [WIDE_W-1:0] pix_c,
    output logic              pix_c_is_cr,
    output logic              trs_stb,
    output logic              trs_f,
    output logic              trs_v,
    output logic              trs_h,
    output logic              trs_err,
    output logic              sync_h,
    output logic              sync_v
);

    localparam int PAD   = WIDE_W - NARROW_W;
    localparam int SLOTS = 2;

    logic [BUS_W-1:0] cap_rise, cap_fall;
    logic             cap_hs, cap_vs, cap_vld;

    vif_cfg_t act_q, cfg_req;

    logic [SLOTS-1:0][WIDE_W-1:0] slot_word;
    logic [SLOTS-1:0]             slot_en;
    logic [SLOTS-1:0]             keep;
    logic [WIDE_W-1:0]            c_lane;
    logic [WIDE_W-1:0]            first_code;
    logic                         xy_hit;
    logic [WIDE_W-1:0]            xy_word;

    logic [NARROW_W-1:0] xy8;
    logic                xy_f, xy_v, xy_h, xy_err, sav_clean;

    vif_capture #(.BUS_W(BUS_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rise (bus_rise),
        .bus_fall (bus_fall),
        .hsync_in (hsync_in),
        .vsync_in (vsync_in),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .cap_hs   (cap_hs),
        .cap_vs   (cap_vs),
        .cap_vld  (cap_vld)
    );

    // Requested configuration as it would be adopted.
    always_comb begin
        cfg_req.mode      = eff_mode(cfg_mode);
        cfg_req.luma_fall = &cfg_luma_edge;
        cfg_req.wide      = cfg_wide;
    end

    // Normalise the captured bus into stream slots for the active format.
    always_comb begin
        logic [WIDE_W-1:0] rise_w, fall_w;
        rise_w = act_q.wide ? cap_rise[BUS_W-1 -: WIDE_W]
                            : {cap_rise[BUS_W-1 -: NARROW_W], {PAD{1'b0}}};
        fall_w = act_q.wide ? cap_fall[BUS_W-1 -: WIDE_W]
                            : {cap_fall[BUS_W-1 -: NARROW_W], {PAD{1'b0}}};
        c_lane = {cap_rise[NARROW_W-1:0], {PAD{1'b0}}};
        case (act_q.mode)
            MODE_DDR: begin
                slot_word  = {fall_w, rise_w};
                slot_en    = {cap_vld, cap_vld};
                first_code = act_q.wide ? {WIDE_W{1'b1}} : {{NARROW_W{1'b1}}, {PAD{1'b0}}};
            end
            MODE_ILV: begin
                slot_word  = {{WIDE_W{1'b0}}, rise_w};
                slot_en    = {1'b0, cap_vld};
                first_code = act_q.wide ? {WIDE_W{1'b1}} : {{NARROW_W{1'b1}}, {PAD{1'b0}}};
            end
            default: begin
                slot_word  = {{WIDE_W{1'b0}}, {cap_rise[BUS_W-1 -: NARROW_W], {PAD{1'b0}}}};
                slot_en    = {1'b0, cap_vld};
                first_code = {{NARROW_W{1'b1}}, {PAD{1'b0}}};
            end
        endcase
    end

    vif_trs_scan #(.WORD_W(WIDE_W), .SLOTS(SLOTS)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (slot_word),
        .slot_en    (slot_en),
        .first_code (first_code),
        .keep_o     (keep),
        .xy_hit     (xy_hit),
        .xy_word    (xy_word)
    );

    // Decode the flag word and its protection bits.
    always_comb begin
        xy8       = xy_word[WIDE_W-1 -: NARROW_W];
        xy_f      = xy8[6];
        xy_v      = xy8[5];
        xy_h      = xy8[4];
        xy_err    = !xy8[7] || (xy8[3:0] != trs_parity(xy_f, xy_v, xy_h))
                    || (|xy_word[PAD-1:0]);
        sav_clean = xy_hit && !xy_h && !xy_err;
    end

    vif_pair_asm #(.WORD_W(WIDE_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (act_q.mode),
        .luma_fall   (act_q.luma_fall),
        .w0          (slot_word[0]),
        .w1          (slot_word[1]),
        .c_lane      (c_lane),
        .keep0       (keep[0]),
        .keep1       (keep[1]),
        .sav_clr     (sav_clean),
        .pix_valid   (pix_valid),
        .pix_y       (pix_y),
        .pix_c       (pix_c),
        .pix_c_is_cr (pix_c_is_cr)
    );

    // Adopt the requested configuration at reset or at a clean start code.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_q <= cfg_req;
        else if (sav_clean) act_q <= cfg_req;
    end

    // Publish decoded timing-code flags with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trs_stb <= 1'b0;
            trs_f   <= 1'b0;
            trs_v   <= 1'b0;
            trs_h   <= 1'b0;
            trs_err <= 1'b0;
        end else begin
            trs_stb <= xy_hit;
            if (xy_hit) begin
                trs_f   <= xy_f;
                trs_v   <= xy_v;
                trs_h   <= xy_h;
                trs_err <= xy_err;
            end
        end
    end

    // Align external sync with the pixel path; interleaved mode blocks it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_h <= 1'b0;
            sync_v <= 1'b0;
        end else begin
            sync_h <= cap_hs && (act_q.mode != MODE_ILV);
            sync_v <= cap_vs && (act_q.mode != MODE_ILV);
        end
    end

endmodule

// File: rtl/vid422_formatter_chk.sv
// Property checker for the formatter, attached by bind. Tracks the expected
// chroma phase and a post-reset arm flag so every property holds from time zero.
module vid422_formatter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] act_mode,
    input logic       pix_valid,
    input logic       pix_c_is_cr,
    input logic       trs_stb,
    input logic       trs_h,
    input logic       trs_err,
    input logic       sync_h,
    input logic       sync_v
);

    logic expect_cb;
    logic last_cr;
    logic armed;

    // Follow the phase the outputs should show.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_cb <= 1'b1;
            last_cr   <= 1'b1;
            armed     <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (trs_stb && !trs_h && !trs_err) expect_cb <= 1'b1;
            else if (pix_valid)                 expect_cb <= 1'b0;
            if (pix_valid) last_cr <= pix_c_is_cr;
        end
    end

    // R8: first pair after reset or a clean start code is Cb
    a_r8_cb_first: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && expect_cb |-> !pix_c_is_cr);

    // R8: the phase alternates between consecutive pairs
    a_r8_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !expect_cb |-> pix_c_is_cr != last_cr);

    // R6: code words never surface as a pair in the same cycle as the strobe
    a_r6_code_not_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        trs_stb |-> !pix_valid);

    // R9: interleaved mode blocks the external sync pins
    a_r9_ilv_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
        act_mode == 2'b10 |=> !sync_h && !sync_v);

    // R1: the active format moves only together with a clean start code
    a_r1_mode_at_sav: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$stable(act_mode) |-> trs_stb && !trs_h && !trs_err);

endmodule

bind vid422_formatter vid422_formatter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_mode    (act_q.mode),
    .pix_valid   (pix_valid),
    .pix_c_is_cr (pix_c_is_cr),
    .trs_stb     (trs_stb),
    .trs_h       (trs_h),
    .trs_err     (trs_err),
    .sync_h      (sync_h),
    .sync_v      (sync_v)
);

// File: tb/vid422_formatter_bench.sv
// Bench: a behavioural word-stream model predicts each clock's outputs;
// predictions are queued and compared two clocks later on the falling edge.
module vid422_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [1:0]  cfg_luma_edge = 2'b00;
    logic        cfg_wide = 1'b0;
    logic [15:0] bus_rise = '0;
    logic [15:0] bus_fall = '0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        pix_valid, pix_c_is_cr, trs_stb, trs_f, trs_v, trs_h, trs_err;
    logic        sync_h, sync_v;
    logic [9:0]  pix_y, pix_c;

    always #5 clk = ~clk;

    vid422_formatter u_vid422_formatter (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_luma_edge(cfg_luma_edge),
        .cfg_wide(cfg_wide), .bus_rise(bus_rise), .bus_fall(bus_fall),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .pix_valid(pix_valid),
        .pix_y(pix_y), .pix_c(pix_c), .pix_c_is_cr(pix_c_is_cr), .trs_stb(trs_stb),
        .trs_f(trs_f), .trs_v(trs_v), .trs_h(trs_h), .trs_err(trs_err),
        .sync_h(sync_h), .sync_v(sync_v)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        bit valid; int y; int c; bit cr;
        bit stb; bit f; bit v; bit h; bit err;
        bit sh; bit sv;
        int mtag; bit wtag; bit r1tag;
    } exp_t;

    exp_t q[$];

    // model state
    int m_mode, m_sel, m_cnt, m_first;
    bit m_wide, m_zok, m_hit, m_phase, m_havec;
    int m_xy, m_chold;
    bit r1_seg = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic scan(input int w, output bit keep);
        keep = 0;
        case (m_cnt)
            0: if (w == m_first) m_cnt = 1; else keep = 1;
            1: begin m_zok = (w == 0); m_cnt = 2; end
            2: begin m_zok = m_zok && (w == 0); m_cnt = 3; end
            default: begin
                if (m_zok) begin m_hit = 1; m_xy = w; end
                m_cnt = 0;
            end
        endcase
    endtask

    task automatic emit(inout exp_t e, input int y, input int c);
        e.valid = 1; e.y = y; e.c = c; e.cr = m_phase;
        m_phase = !m_phase;
    endtask

    function automatic int norm(input logic [15:0] b, input bit wide);
        return wide ? int'(b >> 6) : int'(b >> 8) << 2;
    endfunction

    task automatic model_step(input logic [15:0] r, input logic [15:0] f,
                              input bit hs, input bit vs, output exp_t e);
        int md, w0, w1;
        bit k0, k1, wd;
        logic [7:0] x8;
        e = '{default: 0};
        m_hit = 0;
        md = (m_mode == 3) ? 0 : m_mode;
        wd = m_wide && md != 0;
        e.sh = (md != 2) && hs;
        e.sv = (md != 2) && vs;
        e.mtag = (md == 0) ? 2 : (md == 1) ? 3 : 5;
        e.wtag = wd;
        e.r1tag = r1_seg;
        m_first = wd ? 1023 : 1020;
        case (md)
            0: begin
                w0 = int'(r >> 8) << 2;
                scan(w0, k0);
                if (k0) emit(e, w0, int'(r & 16'h00FF) << 2);
            end
            1: begin
                w0 = norm(r, wd); w1 = norm(f, wd);
                scan(w0, k0); scan(w1, k1);
                if (k0 && k1) emit(e, (m_sel == 3) ? w1 : w0, (m_sel == 3) ? w0 : w1);
            end
            default: begin
                w0 = norm(r, wd);
                scan(w0, k0);
                if (k0) begin
                    if (m_havec) begin emit(e, w0, m_chold); m_havec = 0; end
                    else begin m_chold = w0; m_havec = 1; end
                end
            end
        endcase
        if (m_hit) begin
            x8 = m_xy[9:2];
            e.stb = 1; e.f = x8[6]; e.v = x8[5]; e.h = x8[4];
            e.err = !x8[7] || (x8[3:0] != {x8[5] ^ x8[4], x8[6] ^ x8[4], x8[6] ^ x8[5],
                                            x8[6] ^ x8[5] ^ x8[4]}) || (m_xy[1:0] != 0);
            if (!e.err && !e.h) begin
                m_phase = 0; m_havec = 0;
                m_mode = cfg_mode; m_sel = cfg_luma_edge; m_wide = cfg_wide;
            end
        end
    endtask

    task automatic compare_front();
        exp_t e;
        string t;
        if (q.size() < 2) return;
        e = q.pop_front();
        t = $sformatf("R%0d%s%s R10", e.mtag, e.wtag ? " R4" : "", e.r1tag ? " R1" : "");
        chk(pix_valid == e.valid, t, pix_valid, e.valid);
        if (e.valid) begin
            chk(pix_y == e.y, t, pix_y, e.y);
            chk(pix_c == e.c, t, pix_c, e.c);
            chk(pix_c_is_cr == e.cr, "R8", pix_c_is_cr, e.cr);
        end
        chk(trs_stb == e.stb, "R6", trs_stb, e.stb);
        if (e.stb) begin
            chk({trs_f, trs_v, trs_h} == {e.f, e.v, e.h}, "R7 fvh", {trs_f, trs_v, trs_h},
                {e.f, e.v, e.h});
            chk(trs_err == e.err, "R7 err", trs_err, e.err);
        end
        chk({sync_h, sync_v} == {e.sh, e.sv}, "R9", {sync_h, sync_v}, {e.sh, e.sv});
    endtask

    task automatic cyc(input logic [15:0] r, input logic [15:0] f = 16'h0,
                       input bit hs = 0, input bit vs = 0);
        exp_t e;
        @(negedge clk);
        compare_front();
        rst_n = 1'b1;
        bus_rise = r; bus_fall = f; hsync_in = hs; vsync_in = vs;
        model_step(r, f, hs, vs, e);
        q.push_back(e);
    endtask

    function automatic logic [15:0] mk(input int w10, input bit wide);
        return wide ? 16'(w10 << 6) : 16'((w10 >> 2) << 8);
    endfunction

    task automatic sdr_code(input logic [7:0] xy);
        cyc(16'hFFFF); cyc(16'h0000); cyc(16'h0000); cyc({xy, xy});
    endtask

    task automatic ddr_code(input logic [7:0] xy, input bit wide);
        cyc(wide ? 16'hFFC0 : 16'hFF00, 16'h0);
        cyc(16'h0, mk(int'(xy) << 2, wide));
    endtask

    task automatic ilv_code(input logic [7:0] xy, input bit wide);
        cyc(wide ? 16'hFFC0 : 16'hFF00); cyc(16'h0); cyc(16'h0);
        cyc(mk(int'(xy) << 2, wide));
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // reset state, R10
        repeat (3) @(negedge clk);
        chk(pix_valid == 0, "R10 reset", pix_valid, 0);
        chk(trs_stb == 0, "R10 reset", trs_stb, 0);
        chk({sync_h, sync_v} == 0, "R10 reset", {sync_h, sync_v}, 0);
        m_mode = 0; m_sel = 0; m_wide = 0; m_cnt = 0; m_zok = 0;
        m_phase = 0; m_havec = 0; m_chold = 0; m_xy = 0;

        // R2: single-rate with sync pattern
        sdr_code(8'h80);
        for (int i = 0; i < 6; i++) cyc(16'((i * 16'h1D3B) ^ 16'h4C21), 16'h0, i[0], i[1]);
        sdr_code(8'h9D);
        cyc(16'h1234, 16'h0, 1, 1);
        sdr_code(8'h9C);                         // R7 parity error
        cyc(16'hFF00); cyc(16'h0000); cyc(16'h0500); cyc(16'h8080); // R6 broken preamble
        cyc(16'h5566);

        // R1: request DDR wide; bad start code must not switch
        r1_seg = 1;
        cfg_mode = 2'b01; cfg_wide = 1; cfg_luma_edge = 2'b00;
        sdr_code(8'h81);
        for (int i = 0; i < 3; i++) cyc(16'(16'h3A5C + i * 16'h0101));
        sdr_code(8'hEC);                         // clean SAV, switch
        r1_seg = 0;

        // R3/R4: DDR wide, luma on rising
        for (int i = 0; i < 4; i++) cyc(mk(10'h040 + i * 77, 1), mk(10'h200 + i * 33, 1), i[0], 0);
        cyc(mk(10'h3FC, 1), mk(10'h155, 1));    // 3FC is pixel in wide mode
        ddr_code(8'hF1, 1);
        cfg_luma_edge = 2'b11; cfg_wide = 0;
        ddr_code(8'hEC, 1);
        // DDR narrow, luma on falling
        for (int i = 0; i < 4; i++) cyc(mk(10'h080 + i * 20, 0), mk(10'h300 - i * 40, 0), 0, i[0]);
        ddr_code(8'h9D, 0);
        cyc(mk(10'h100, 0), mk(10'h0F0, 0));

        // R5: switch to interleaved wide via narrow DDR start code
        cfg_mode = 2'b10; cfg_wide = 1;
        ddr_code(8'h80, 0);
        for (int i = 0; i < 8; i++) cyc(mk(10'h010 + i * 91, 1), 16'hBEEF, 1, 1);
        ilv_code(8'h9D, 1);
        cyc(mk(10'h123, 1), 16'h0, 1, 0);
        cfg_wide = 0;
        ilv_code(8'h80, 1);
        for (int i = 0; i < 6; i++) cyc(mk(10'h044 + i * 64, 0), 16'hFFFF, 0, 1);

        // back to single rate
        cfg_mode = 2'b00;
        ilv_code(8'hEC, 0);
        for (int i = 0; i < 4; i++) cyc(16'(16'h2B4D + i * 16'h1111), 16'h0, 1, i[0]);

        repeat (3) cyc(16'h1010);
        @(negedge clk); compare_front();
        @(negedge clk); compare_front();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule